// File: doc/BRIEF.md
# Tone Generator with Fractional Reference

This block drives an alerter with a square-wave tone. The block's clock is a 76.8 kHz input. A divisor counter runs on a selectable timing reference and flips the tone output each time it completes a count. The reference is either every input clock or a derived pulse stream that averages exactly 32768 Hz. That stream is not made by an integer divider. It comes from a fixed 75-clock insertion pattern that emits 32 one-clock pulses.

Software sets up the block through a write-strobe port with two registers. Address 0 holds the 8-bit divisor. Address 1 is the control register: bit 0 enables the tone and bit 1 selects the derived reference. With divisor N, the tone frequency is the reference rate divided by 2×(N+1). A new divisor is picked up only when the running count wraps, so a period in progress is never cut short. Clearing the enable bit resets the counter, the tone and the pattern position, so the next enable starts from a known phase. The derived pulse stream is also brought out on its own output.

Top module: `tone_gen_top`

## Requirements
- R1: After reset the block is disabled, `tone_o` is 0 and `ref_tick_o` is 0.
- R2: While the enable bit is 0, `tone_o` and `ref_tick_o` stay 0, including after divisor writes.
- R3: A write with `wr_en` high is taken at the clock edge. `wr_addr` 0 loads the divisor from `wr_data`. `wr_addr` 1 loads control: `wr_data` bit 0 is enable and bit 1 is reference select (1 = derived reference).
- R4: With select 0 and divisor N, the first change of `tone_o` appears N+1 clocks after the enabling edge. Each later change follows N+1 clocks after the one before; N = 0 and N = 255 are included.
- R5: While enabled, `ref_tick_o` is high for one clock at fixed pattern positions p (counted from 0 at the first enabled clock, modulo 75). For p < 70 it is high when p mod 7 is 0, 2 or 4. For p ≥ 70 it is high when p−70 is 0 or 2.
- R6: Every 75-clock window of the pattern holds exactly 32 pulses on `ref_tick_o`.
- R7: With select 1 and divisor N, `tone_o` changes once every N+1 reference pulses, and only on those pulses.
- R8: A divisor written while the tone runs leaves the current half-period unchanged and applies from the next counter wrap.
- R9: Clearing enable forces `tone_o` to 0 at once. Enabling again restarts both the pattern at position 0 and the divisor count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 76.8 kHz block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Register select: 0 divisor, 1 control |
| wr_data | input | 8 | Write data |
| tone_o | output | 1 | Alerter tone output |
| ref_tick_o | output | 1 | Derived 32768 Hz-average reference pulse |

## Verification
The in-line assertions check these properties on every cycle:
- the pattern position and group index stay in range, and the short group never goes past its length;
- reference pulses never fall on two clocks in a row;
- the count never passes the divisor in use;
- the tone and count hold between reference pulses;
- the divisor in use changes only at a wrap;
- the tone clears when the block is disabled.

Some behaviour only the bench scenarios can show. These are the exact pulse positions and the total of 32 per 75-clock window. They also include the half-period length for small, zero and full-scale divisors and the timing of a mid-period divisor change. The last is the phase restart after a disable and a new enable.

// File: rtl/tone_pkg.sv
package tone_pkg;
    localparam int unsigned TONE_DIV_W   = 8;
    localparam int unsigned CTRL_EN_BIT  = 0;
    localparam int unsigned CTRL_SEL_BIT = 1;

    typedef enum logic {
        ADDR_DIV  = 1'b0,
        ADDR_CTRL = 1'b1
    } reg_addr_e;
endpackage

// File: rtl/tone_regs.sv
module tone_regs
    import tone_pkg::*;
#(
    parameter int unsigned DIV_W = TONE_DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [DIV_W-1:0] wr_data,
    output logic [DIV_W-1:0] div_o,
    output logic             en_o,
    output logic             sel_o
);
    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             en;
        logic             sel;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            if (wr_addr == ADDR_DIV) begin
                r_d.div = wr_data;
            end else begin
                r_d.en  = wr_data[CTRL_EN_BIT];
                r_d.sel = wr_data[CTRL_SEL_BIT];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign div_o = r_q.div;
    assign en_o  = r_q.en;
    assign sel_o = r_q.sel;

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(r_q.en) && $stable(r_q.sel) && $stable(r_q.div))); // R3
endmodule

// File: rtl/frac_ref_gen.sv
module frac_ref_gen #(
    parameter int LONG_LEN     = 7,
    parameter int LONG_PULSES  = 3,
    parameter int LONG_GROUPS  = 10,
    parameter int SHORT_LEN    = 5,
    parameter int SHORT_PULSES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int POS_W = $clog2(LONG_LEN);
    localparam int GRP_W = $clog2(LONG_GROUPS + 1);

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic [GRP_W-1:0] grp;
    } pat_t;

    pat_t p_d, p_q;
    logic last_grp;
    int   grp_len;
    int   grp_pulses;

    always_comb begin
        last_grp   = (p_q.grp == GRP_W'(LONG_GROUPS));
        grp_len    = last_grp ? SHORT_LEN : LONG_LEN;
        grp_pulses = last_grp ? SHORT_PULSES : LONG_PULSES;
        tick_o     = run_i && !p_q.pos[0] && (int'(p_q.pos) < 2 * grp_pulses);

        p_d = p_q;
        if (!run_i) begin
            p_d = '0;
        end else if (p_q.pos == POS_W'(grp_len - 1)) begin
            p_d.pos = '0;
            p_d.grp = last_grp ? '0 : p_q.grp + 1'b1;
        end else begin
            p_d.pos = p_q.pos + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    AST_POS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(p_q.pos) < LONG_LEN); // R5
    AST_GRP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(p_q.grp) <= LONG_GROUPS); // R6
    AST_SHORT_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        last_grp |-> (int'(p_q.pos) < SHORT_LEN)); // R6
    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o); // R5
endmodule

// File: rtl/tone_divider.sv
module tone_divider #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             ref_en_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tone_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] div_act;
        logic             tone;
    } div_t;

    div_t s_d, s_q;
    logic wrap;

    always_comb begin
        wrap = ref_en_i && (s_q.cnt == s_q.div_act);
        s_d  = s_q;
        if (!en_i) begin
            s_d.cnt     = '0;
            s_d.tone    = 1'b0;
            s_d.div_act = div_i;
        end else if (wrap) begin
            s_d.cnt     = '0;
            s_d.tone    = ~s_q.tone;
            s_d.div_act = div_i;
        end else if (ref_en_i) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tone_o = s_q.tone;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= s_q.div_act); // R4
    AST_TONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !s_q.tone); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !ref_en_i) |=> ($stable(s_q.tone) && $stable(s_q.cnt))); // R7
    AST_DIV_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !(ref_en_i && s_q.cnt == s_q.div_act)) |=> $stable(s_q.div_act)); // R8
endmodule

// File: rtl/tone_gen_top.sv
module tone_gen_top
    import tone_pkg::*;
#(
    parameter int unsigned DIV_W = TONE_DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [DIV_W-1:0] wr_data,
    output logic             tone_o,
    output logic             ref_tick_o
);
    logic [DIV_W-1:0] div_q;
    logic             en_q;
    logic             sel_q;
    logic             frac_tick;
    logic             ref_en;
    logic             tone_raw;

    tone_regs #(.DIV_W(DIV_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .div_o   (div_q),
        .en_o    (en_q),
        .sel_o   (sel_q)
    );

    frac_ref_gen u_ref (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (en_q),
        .tick_o (frac_tick)
    );

    assign ref_en = sel_q ? frac_tick : 1'b1;

    tone_divider #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en_q),
        .ref_en_i (ref_en),
        .div_i    (div_q),
        .tone_o   (tone_raw)
    );

    assign tone_o     = tone_raw & en_q;
    assign ref_tick_o = frac_tick;

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> (!tone_o && !ref_tick_o)); // R2
endmodule

// File: tb/sim_tone_gen_top.sv
module sim_tone_gen_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = '0;
    logic       tone_o;
    logic       ref_tick_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    tone_gen_top u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tone_o(tone_o), .ref_tick_o(ref_tick_o)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int pat_tick(int p);
        int q;
        p = p % 75;
        if (p < 70) begin
            q = p % 7;
            return (q == 0 || q == 2 || q == 4) ? 1 : 0;
        end
        q = p - 70;
        return (q == 0 || q == 2) ? 1 : 0;
    endfunction

    // Drive one write; returns at the negedge of the first cycle after the write edge.
    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 tone after reset", int'(tone_o), 0);
        check("R1 tick after reset", int'(ref_tick_o), 0);
    endtask

    task automatic t_disabled();
        int act_t = 0;
        int act_k = 0;
        wr(1'b0, 8'd5);
        for (int i = 0; i < 30; i++) begin
            act_t += int'(tone_o);
            act_k += int'(ref_tick_o);
            @(negedge clk);
        end
        check("R2 tone while disabled", act_t, 0);
        check("R2 tick while disabled", act_k, 0);
    endtask

    task automatic t_direct(int n);
        int chg[3];
        int k = 0;
        logic prev;
        wr(1'b0, 8'(n));
        wr(1'b1, 8'h01);
        prev = tone_o;
        for (int i = 0; i <= 3 * (n + 1) + 2; i++) begin
            if (tone_o !== prev && k < 3) begin
                chg[k] = i;
                k++;
            end
            prev = tone_o;
            @(negedge clk);
        end
        check("R4 direct change count", k, 3);
        for (int j = 0; j < 3; j++) check("R4 direct change cycle", chg[j], (n + 1) * (j + 1));
        wr(1'b1, 8'h00);
        check("R9 tone zero on disable", int'(tone_o), 0);
    endtask

    task automatic t_frac_pattern();
        int win;
        int bad_pos = 0;
        int toggles = 0;
        logic prev;
        wr(1'b0, 8'd1);
        wr(1'b1, 8'h03);
        prev = tone_o;
        for (int w = 0; w < 10; w++) begin
            win = 0;
            for (int p = 0; p < 75; p++) begin
                if (int'(ref_tick_o) != pat_tick(p)) bad_pos++;
                win += int'(ref_tick_o);
                if (tone_o !== prev) toggles++;
                prev = tone_o;
                @(negedge clk);
            end
            check("R6 pulses per 75-clock window", win, 32);
        end
        if (tone_o !== prev) toggles++;
        check("R5 pulse positions mismatched", bad_pos, 0);
        check("R7 derived-reference tone toggles", toggles, 160);
        wr(1'b1, 8'h00);
    endtask

    task automatic t_div_change();
        int chg[3];
        int k = 0;
        logic prev;
        wr(1'b0, 8'd9);
        wr(1'b1, 8'h01);
        prev = tone_o;
        for (int i = 0; i < 20; i++) begin
            if (tone_o !== prev && k < 3) begin
                chg[k] = i;
                k++;
            end
            prev = tone_o;
            wr_en = (i == 2);
            wr_addr = 1'b0;
            wr_data = 8'd2;
            @(negedge clk);
        end
        wr_en = 1'b0;
        check("R8 change count", k, 3);
        check("R8 old half-period kept", chg[0], 10);
        check("R8 new divisor after wrap", chg[1], 13);
        check("R8 new divisor steady", chg[2], 16);
        wr(1'b1, 8'h00);
    endtask

    task automatic t_restart();
        int bad_pos = 0;
        int first = -1;
        int act_t = 0;
        int act_k = 0;
        logic prev;
        wr(1'b0, 8'd2);
        wr(1'b1, 8'h03);
        for (int i = 0; i < 37; i++) @(negedge clk);
        wr(1'b1, 8'h00);
        for (int i = 0; i < 5; i++) begin
            act_t += int'(tone_o);
            act_k += int'(ref_tick_o);
            @(negedge clk);
        end
        check("R9 tone held off after disable", act_t, 0);
        check("R2 tick held off after disable", act_k, 0);
        wr(1'b1, 8'h03);
        prev = tone_o;
        for (int i = 0; i < 21; i++) begin
            if (int'(ref_tick_o) != pat_tick(i)) bad_pos++;
            if (tone_o !== prev && first < 0) first = i;
            prev = tone_o;
            @(negedge clk);
        end
        check("R9 pattern restarts at position 0", bad_pos, 0);
        check("R9 count restarts from zero", first, 5);
        wr(1'b1, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_direct(3);
        t_direct(0);
        t_direct(255);
        t_frac_pattern();
        t_div_change();
        t_restart();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule